// File: doc/BRIEF.md
# USB Device Control and Interrupt Register Bank

This block is the byte-wide register bank of a small USB device controller. A local processor reaches it through a simple bus with a select, a write strobe, an address and separate write and read data. It holds four registers: a control register, an interrupt enable register, a device address register and an interrupt status register. Event pulses from the endpoint, DMA, start-of-frame and bus-reset logic set latched status bits. Software clears them by writing ones. The enabled pending bits are combined into a single registered interrupt request.

The control register drives the rest of the device. It selects the signalling speed and requests the low-power state. It can also force the bus lines into SE0, K or J, which is used for reset and resume signalling. The stored device address is compared against the address of each incoming token, and the result is given as a match flag. A DMA-busy level from the DMA engine is shown live in the top bit of the status register.

Top module: `usbdev_regbank`

## Requirements
- R1: A synchronous active-high reset clears every register to 00h, and drops `irq`, `force_en`, `dp_out`, `dm_out`, `low_speed` and `suspend` to 0.
- R2: The registers sit at these addresses: control at 05h, interrupt enable at 06h, device address at 07h, interrupt status at 0Dh. Control and device address read back the full byte written. The enable register stores bits 6..0 and reads bit 7 as 0. Read data is combinational from `bus_addr`.
- R3: A one-cycle event pulse sets the matching status bit on the next clock: `ep_done[3:0]` sets bits 3..0, `dma_done` sets bit 4, `sof` sets bit 5 and `bus_reset` sets bit 6. Each bit stays set until it is cleared.
- R4: A write to the status address clears each bit 6..0 whose write-data bit is 1. Bits written with 0 keep their value.
- R5: An event pulse in the same cycle as a write-one clear of the same bit wins, and the bit stays set.
- R6: Status bit 7 reads the live `dma_busy` input (1 = DMA in progress) and never raises `irq`.
- R7: `irq` is a register loaded each clock with the OR of (status[6:0] AND enable[6:0]). It rises one clock after an enabled bit is set and falls one clock after the last enabled pending bit is cleared. A pending bit that is not enabled has no effect on `irq`.
- R8: `addr_match` is 1 exactly when `tok_addr[6:0]` equals bits 6..0 of the device address register, which is 00h after reset.
- R9: `low_speed` follows control bit 5 (0 = full speed 12 MHz, 1 = low speed 1.5 MHz).
- R10: `suspend` is 1 only when control bit 6 is 1 and control bit 0 (USB enable) is 0.
- R11: Control bits {4,3} select the line drive. 00 is normal (`force_en`=0, `dp_out`=0, `dm_out`=0). 01 forces SE0 (`force_en`=1, both low). 10 forces K (`dm_out`=1, `dp_out`=0). 11 forces J (`dp_out`=1, `dm_out`=0).
- R12: Reads from any other address return 00h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | ADDR_W (8) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ep_done | input | 4 | Endpoint 0..3 done pulses |
| dma_done | input | 1 | DMA done pulse |
| sof | input | 1 | Start-of-frame received pulse |
| bus_reset | input | 1 | USB bus reset received pulse |
| dma_busy | input | 1 | Live DMA-in-progress level |
| tok_addr | input | 7 | Address field of the current token |
| addr_match | output | 1 | Token address equals the device address |
| irq | output | 1 | Registered interrupt request |
| low_speed | output | 1 | Speed select, 1 = low speed |
| suspend | output | 1 | Low-power request to the transceiver |
| force_en | output | 1 | Forced line drive active |
| dp_out | output | 1 | Forced D+ level |
| dm_out | output | 1 | Forced D- level |

## Verification
The bench first checks that a pending bit held back by its enable leaves `irq` low, and that `irq` trails status by exactly one clock when it rises and when it falls. A combinational request would show up one cycle early. An unregistered clear would show up one cycle late. It then raises an event pulse in the same cycle as a write-one clear of that bit. A design that lets the clear win would lose that event. It also writes zeros to pending bits, raises `dma_busy` with every enable set, and walks all four line-drive codes, including the case where suspend must stay off because USB enable is set. The map is probed with writes to addresses that no register uses, which must change no register.

// File: rtl/usbdev_pkg.sv
`timescale 1ns/1ps
package usbdev_pkg;

    localparam int DATA_W   = 8;
    localparam int EP_COUNT = 4;
    // latched event bits: endpoints, then dma done, sof, bus reset
    localparam int EVT_W    = EP_COUNT + 3;

    typedef struct packed {
        logic       spare7;
        logic       lowpwr_req;
        logic       slow_mode;
        logic       jk_drive;
        logic       eng_hold;
        logic [1:0] spare21;
        logic       usb_on;
    } ctrl_reg_t;

    typedef enum logic [1:0] {
        LINE_NORMAL = 2'b00,
        LINE_SE0    = 2'b01,
        LINE_K      = 2'b10,
        LINE_J      = 2'b11
    } line_mode_e;

    typedef struct packed {
        logic force_en;
        logic dp;
        logic dm;
    } line_drv_t;

    function automatic line_drv_t decode_line(line_mode_e mode);
        line_drv_t d;
        case (mode)
            LINE_SE0: d = '{force_en: 1'b1, dp: 1'b0, dm: 1'b0};
            LINE_K:   d = '{force_en: 1'b1, dp: 1'b0, dm: 1'b1};
            LINE_J:   d = '{force_en: 1'b1, dp: 1'b1, dm: 1'b0};
            default:  d = '{force_en: 1'b0, dp: 1'b0, dm: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/usbdev_ctrl.sv
`timescale 1ns/1ps
module usbdev_ctrl
    import usbdev_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_reg_t         ctrl_q,
    output logic              low_speed,
    output logic              suspend,
    output logic              force_en,
    output logic              dp_out,
    output logic              dm_out
);

    line_drv_t drv;

    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= '0;
        else if (we) ctrl_q <= ctrl_reg_t'(wdata);
    end

    always_comb begin
        drv       = decode_line(line_mode_e'({ctrl_q.jk_drive, ctrl_q.eng_hold}));
        force_en  = drv.force_en;
        dp_out    = drv.dp;
        dm_out    = drv.dm;
        low_speed = ctrl_q.slow_mode;
        suspend   = ctrl_q.lowpwr_req & ~ctrl_q.usb_on;
    end

    // R11: J and K never driven together; idle lines stay low
    p_line_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(dp_out && dm_out));
    p_idle_low_r11: assert property (@(posedge clk) disable iff (rst)
        !force_en |-> (!dp_out && !dm_out));

endmodule

// File: rtl/usbdev_intr.sv
`timescale 1ns/1ps
module usbdev_intr
    import usbdev_pkg::*;
#(
    parameter int NBITS = EVT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_we,
    input  logic              sts_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NBITS-1:0]  ev,
    output logic [NBITS-1:0]  en_q,
    output logic [NBITS-1:0]  sts_q,
    output logic              irq
);

    logic [NBITS-1:0] clr_mask;

    assign clr_mask = sts_we ? wdata[NBITS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_we) en_q <= wdata[NBITS-1:0];
    end

    for (genvar i = 0; i < NBITS; i++) begin : g_sts
        always_ff @(posedge clk) begin
            if (rst)        sts_q[i] <= 1'b0;
            else if (ev[i]) sts_q[i] <= 1'b1;
            else if (clr_mask[i]) sts_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(sts_q & en_q);
    end

    // R4: a cleared bit with no event is zero next cycle
    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (sts_we && |(wdata[NBITS-1:0] & ~ev))
        |=> ((sts_q & $past(wdata[NBITS-1:0] & ~ev)) == '0));
    // R5: a pulsed bit is set next cycle whatever was written
    p_evt_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (|ev) |=> ((sts_q & $past(ev)) == $past(ev)));
    // R7: request follows enabled pending bits one clock later
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (|(sts_q & en_q)) |=> irq);
    p_irq_fall_r7: assert property (@(posedge clk) disable iff (rst)
        ((sts_q & en_q) == '0) |=> !irq);

endmodule

// File: rtl/usbdev_regbank.sv
`timescale 1ns/1ps
module usbdev_regbank
    import usbdev_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'h05,
    parameter logic [ADDR_W-1:0] IEN_ADDR   = 'h06,
    parameter logic [ADDR_W-1:0] DADDR_ADDR = 'h07,
    parameter logic [ADDR_W-1:0] ISTS_ADDR  = 'h0D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [3:0]        ep_done,
    input  logic              dma_done,
    input  logic              sof,
    input  logic              bus_reset,
    input  logic              dma_busy,
    input  logic [6:0]        tok_addr,
    output logic              addr_match,
    output logic              irq,
    output logic              low_speed,
    output logic              suspend,
    output logic              force_en,
    output logic              dp_out,
    output logic              dm_out
);

    localparam int PAD_W = DATA_W - EVT_W;

    logic              wr_go;
    logic              we_ctrl, we_ien, we_dadr, we_ists, unmapped;
    ctrl_reg_t         ctrl_q;
    logic [EVT_W-1:0]  en_q, sts_q, ev_vec;
    logic [DATA_W-1:0] dev_addr_q;

    assign wr_go    = bus_sel & bus_wr;
    assign we_ctrl  = wr_go && (bus_addr == CTRL_ADDR);
    assign we_ien   = wr_go && (bus_addr == IEN_ADDR);
    assign we_dadr  = wr_go && (bus_addr == DADDR_ADDR);
    assign we_ists  = wr_go && (bus_addr == ISTS_ADDR);
    assign unmapped = (bus_addr != CTRL_ADDR) && (bus_addr != IEN_ADDR) &&
                      (bus_addr != DADDR_ADDR) && (bus_addr != ISTS_ADDR);

    assign ev_vec = {bus_reset, sof, dma_done, ep_done};

    usbdev_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .we        (we_ctrl),
        .wdata     (bus_wdata),
        .ctrl_q    (ctrl_q),
        .low_speed (low_speed),
        .suspend   (suspend),
        .force_en  (force_en),
        .dp_out    (dp_out),
        .dm_out    (dm_out)
    );

    usbdev_intr #(.NBITS(EVT_W)) u_intr (
        .clk    (clk),
        .rst    (rst),
        .en_we  (we_ien),
        .sts_we (we_ists),
        .wdata  (bus_wdata),
        .ev     (ev_vec),
        .en_q   (en_q),
        .sts_q  (sts_q),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)          dev_addr_q <= '0;
        else if (we_dadr) dev_addr_q <= bus_wdata;
    end

    assign addr_match = (tok_addr == dev_addr_q[6:0]);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR)       bus_rdata = DATA_W'(ctrl_q);
        else if (bus_addr == IEN_ADDR)   bus_rdata = {{PAD_W{1'b0}}, en_q};
        else if (bus_addr == DADDR_ADDR) bus_rdata = dev_addr_q;
        else if (bus_addr == ISTS_ADDR)  bus_rdata = {dma_busy, {(PAD_W-1){1'b0}}, sts_q};
    end

    // R12: a write to an unused address leaves every register as it was
    p_unmapped_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_go && unmapped && !(|ev_vec))
        |=> ($stable(ctrl_q) && $stable(en_q) && $stable(dev_addr_q) && $stable(sts_q)));
    // R8: a device address write is held from the next cycle
    p_addr_load_r8: assert property (@(posedge clk) disable iff (rst)
        we_dadr |=> (dev_addr_q == $past(bus_wdata)));

endmodule

// File: tb/sim_usbdev_regbank.sv
`timescale 1ns/1ps
module sim_usbdev_regbank;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] ep_done = '0;
    logic       dma_done = 1'b0, sof = 1'b0, bus_reset = 1'b0, dma_busy = 1'b0;
    logic [6:0] tok_addr = '0;
    logic       addr_match, irq, low_speed, suspend, force_en, dp_out, dm_out;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    usbdev_regbank u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ep_done(ep_done), .dma_done(dma_done), .sof(sof), .bus_reset(bus_reset),
        .dma_busy(dma_busy), .tok_addr(tok_addr), .addr_match(addr_match),
        .irq(irq), .low_speed(low_speed), .suspend(suspend),
        .force_en(force_en), .dp_out(dp_out), .dm_out(dm_out)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // pulse a 7-bit event vector {bus_reset,sof,dma_done,ep_done}
    task automatic pulse(logic [6:0] v);
        @(negedge clk);
        {bus_reset, sof, dma_done, ep_done} = v;
        @(negedge clk);
        {bus_reset, sof, dma_done, ep_done} = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 line", {5'b0, force_en, dp_out, dm_out}, 8'h00);
        check("R1 speed/suspend", {6'b0, low_speed, suspend}, 8'h00);
        rd(8'h05, d); check("R1 ctrl", d, 8'h00);
        rd(8'h06, d); check("R1 enable", d, 8'h00);
        rd(8'h07, d); check("R1 addr", d, 8'h00);
        rd(8'h0D, d); check("R1 status", d, 8'h00);
    endtask

    task automatic t_map();
        logic [7:0] d;
        wr(8'h07, 8'hA5); rd(8'h07, d); check("R2 addr readback", d, 8'hA5);
        wr(8'h06, 8'hFF); rd(8'h06, d); check("R2 enable bit7 reads 0", d, 8'h7F);
        wr(8'h06, 8'h00);
        wr(8'h05, 8'h81); rd(8'h05, d); check("R2 ctrl readback", d, 8'h81);
        wr(8'h05, 8'h00);
    endtask

    task automatic t_events();
        logic [7:0] d;
        pulse(7'b000_0100); rd(8'h0D, d); check("R3 ep2 -> bit2", d, 8'h04);
        pulse(7'b001_0000); rd(8'h0D, d); check("R3 dma done -> bit4", d, 8'h14);
        pulse(7'b110_1001); rd(8'h0D, d); check("R3 sof/reset/ep0/ep3", d, 8'h7D);
        repeat (3) @(negedge clk);
        rd(8'h0D, d); check("R3 bits hold", d, 8'h7D);
    endtask

    task automatic t_w1c();
        logic [7:0] d;
        wr(8'h0D, 8'h00); rd(8'h0D, d); check("R4 zeros no effect", d, 8'h7D);
        wr(8'h0D, 8'h14); rd(8'h0D, d); check("R4 clear bits 4,2", d, 8'h69);
        wr(8'h0D, 8'h7F); rd(8'h0D, d); check("R4 clear all", d, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        pulse(7'b000_0011);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h0D; bus_wdata = 8'h03;
        ep_done = 4'b0010;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; ep_done = '0;
        rd(8'h0D, d); check("R5 event beats clear", d, 8'h02);
        wr(8'h0D, 8'h02);
    endtask

    task automatic t_dma();
        logic [7:0] d;
        wr(8'h06, 8'h7F);
        dma_busy = 1'b1;
        rd(8'h0D, d); check("R6 busy shows in bit7", d, 8'h80);
        repeat (2) @(negedge clk);
        check("R6 busy raises no irq", {7'b0, irq}, 8'h00);
        dma_busy = 1'b0;
        rd(8'h0D, d); check("R6 busy drop", d, 8'h00);
        wr(8'h06, 8'h00);
    endtask

    task automatic t_irq();
        wr(8'h06, 8'h02);
        pulse(7'b010_0000);
        @(negedge clk);
        check("R7 disabled bit no irq", {7'b0, irq}, 8'h00);
        pulse(7'b000_0010);
        check("R7 irq not yet", {7'b0, irq}, 8'h00);
        @(negedge clk);
        check("R7 irq one clock later", {7'b0, irq}, 8'h01);
        wr(8'h0D, 8'h02);
        check("R7 irq held one clock after clear", {7'b0, irq}, 8'h01);
        @(negedge clk);
        check("R7 irq drops", {7'b0, irq}, 8'h00);
        wr(8'h0D, 8'h20);
        wr(8'h06, 8'h00);
    endtask

    task automatic t_match();
        wr(8'h07, 8'h00);
        tok_addr = 7'h00; #1 check("R8 match addr 0 default", {7'b0, addr_match}, 8'h01);
        wr(8'h07, 8'h2A);
        tok_addr = 7'h2A; #1 check("R8 match", {7'b0, addr_match}, 8'h01);
        tok_addr = 7'h2B; #1 check("R8 mismatch", {7'b0, addr_match}, 8'h00);
        tok_addr = 7'h00; #1 check("R8 old addr", {7'b0, addr_match}, 8'h00);
    endtask

    task automatic t_speed_suspend();
        wr(8'h05, 8'h20); check("R9 low speed", {7'b0, low_speed}, 8'h01);
        wr(8'h05, 8'h00); check("R9 full speed", {7'b0, low_speed}, 8'h00);
        wr(8'h05, 8'h40); check("R10 suspend", {7'b0, suspend}, 8'h01);
        wr(8'h05, 8'h41); check("R10 enabled no suspend", {7'b0, suspend}, 8'h00);
        wr(8'h05, 8'h01); check("R10 no request", {7'b0, suspend}, 8'h00);
    endtask

    task automatic t_line();
        wr(8'h05, 8'h08); check("R11 SE0", {5'b0, force_en, dp_out, dm_out}, 8'h04);
        wr(8'h05, 8'h10); check("R11 K", {5'b0, force_en, dp_out, dm_out}, 8'h05);
        wr(8'h05, 8'h18); check("R11 J", {5'b0, force_en, dp_out, dm_out}, 8'h06);
        wr(8'h05, 8'h00); check("R11 normal", {5'b0, force_en, dp_out, dm_out}, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        wr(8'h07, 8'h11);
        wr(8'h03, 8'hFF);
        wr(8'h0E, 8'hFF);
        wr(8'h15, 8'hFF);
        rd(8'h03, d); check("R12 unused reads 0", d, 8'h00);
        rd(8'h05, d); check("R12 ctrl kept", d, 8'h00);
        rd(8'h06, d); check("R12 enable kept", d, 8'h00);
        rd(8'h07, d); check("R12 addr kept", d, 8'h11);
        rd(8'h0D, d); check("R12 status kept", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_events();
        t_w1c();
        t_collide();
        t_dma();
        t_irq();
        t_match();
        t_speed_suspend();
        t_line();
        t_unmapped();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule